// File: doc/BRIEF.md
# Line Error Counter Bank

This block holds the error counters of a T1 receive monitor. It has one 16-bit counter that counts either bipolar violations or excess-zero runs, and three 8-bit counters for CRC word errors, out-of-frame events and framing-bit errors. Each counter takes single-cycle event strobes that the framer and the line decoder have already qualified. Mode inputs select which strobes count: extended-superframe or superframe framing, B8ZS enable, excess-zero mode and FS-error inclusion. A loss-of-sync flag also gates the counters.

A host reaches the counters through a byte-wide register port. A write presets a counter to a threshold. From there the counter counts upward and sticks at all ones. Every event that arrives while a counter is stuck at all ones sets that counter's saturation flag. A masked OR of the four flags drives an interrupt line. A read returns a snapshot of the addressed byte. When auto-clear is enabled, any read also zeroes all four counters. An event in the same cycle as that read is applied after the clear, so no event is lost.

Top module: `line_err_counters`

## Requirements
- R1: After reset, all counters read 0, `sat_flag` is 0 and `irq` is 0. The register addresses are 0 (violation counter low byte), 1 (violation counter high byte), 2 (CRC), 3 (out-of-frame) and 4 (frame error). Read data appears on `reg_rdata` in the cycle after `reg_rd`. Any other address reads 0.
- R2: A write to address 1 loads the violation counter with {wdata, staged low byte}. A write to address 0 only stages the low byte and leaves the count unchanged. A write to address 2, 3 or 4 loads that 8-bit counter. A write to a counter clears that counter's saturation flag.
- R3: Each counter increments by one per qualified event and holds at all ones (65535 or 255). It never wraps.
- R4: An event that is qualified while the counter is at all ones sets that counter's bit of `sat_flag` in the next cycle. The bit positions are 0 (violation), 1 (CRC), 2 (out-of-frame) and 3 (frame error). `irq` is the OR of `sat_flag & irq_mask`.
- R5: While `los` is high, events for the CRC, out-of-frame and frame-error counters are ignored. The violation counter keeps counting.
- R6: With `cfg_esf` low, the CRC counter is held at 0 and writes to it are ignored. With `cfg_esf` high, `ev_crc` counts.
- R7: In violation mode (`cfg_zero_mode` low), `ev_bpv` counts. When `cfg_b8zs_en` is high, a violation strobed together with `ev_bpv_code` (part of a substitution code word) is not counted.
- R8: In excess-zero mode (`cfg_zero_mode` high), the 16-bit counter counts `ev_zero8` when `cfg_b8zs_en` is high and `ev_zero16` when it is low. `ev_bpv` is ignored in this mode.
- R9: In superframe mode, the frame-error counter counts `ev_ft_err`, and it also counts `ev_fs_err` when `cfg_fs_count` is high. In extended-superframe mode it counts only `ev_fps_err`.
- R10: With `cfg_auto_clr` high, a read returns the value before the clear and zeroes all four counters. An event in the same cycle leaves that counter at 1. With `cfg_auto_clr` low, reads leave the counts unchanged.

Ports table: width 8 is the byte width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_esf | input | 1 | 1 = extended superframe, 0 = superframe |
| cfg_b8zs_en | input | 1 | B8ZS line code enabled |
| cfg_zero_mode | input | 1 | 16-bit counter counts excess-zero runs |
| cfg_fs_count | input | 1 | Superframe: count FS errors too |
| cfg_auto_clr | input | 1 | Reads clear all counters |
| los | input | 1 | Loss of sync |
| ev_bpv | input | 1 | Bipolar violation strobe |
| ev_bpv_code | input | 1 | Violation belongs to a substitution code word |
| ev_zero8 | input | 1 | Run of 8 zeros strobe |
| ev_zero16 | input | 1 | Run of 16 zeros strobe |
| ev_crc | input | 1 | CRC word error strobe |
| ev_oof | input | 1 | Out-of-frame event strobe |
| ev_ft_err | input | 1 | FT framing bit error strobe |
| ev_fs_err | input | 1 | FS framing bit error strobe |
| ev_fps_err | input | 1 | FPS framing bit error strobe |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| irq_mask | input | 4 | Interrupt enable per counter |
| sat_flag | output | 4 | Saturation flags per counter |
| irq | output | 1 | Masked interrupt |

## Verification
The bench presets counters just below all ones and drives them past that point. A design that wraps instead of holding would read back a small count, and one that flags the step into all ones would raise `sat_flag` one event too early. It writes only the low byte of the 16-bit preset and reads both bytes back, which exposes a design that loads that byte immediately. It also reads with auto-clear on while an event arrives in the same cycle: if the event is dropped the count reads 0 instead of 1, and if the clear is applied late the returned value is wrong. The gating of each mode is exercised in both settings, including loss of sync, superframe CRC hold and B8ZS code words, so that a strobe counted under the wrong mode shows up as an off-by-one count.

// File: rtl/err_cnt_pkg.sv
package err_cnt_pkg;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 3;
  localparam int N_CNT   = 4;
  localparam int BV_IDX  = 0;
  localparam int CRC_IDX = 1;
  localparam int OOF_IDX = 2;
  localparam int FE_IDX  = 3;

  localparam logic [ADDR_W-1:0] A_BV_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_BV_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CRC   = 3'd2;
  localparam logic [ADDR_W-1:0] A_OOF   = 3'd3;
  localparam logic [ADDR_W-1:0] A_FE    = 3'd4;

  // Address of the 8-bit counter with index i (1..3)
  function automatic logic [ADDR_W-1:0] small_addr(input int i);
    return ADDR_W'(i + 1);
  endfunction
endpackage

// File: rtl/ev_qualify.sv
module ev_qualify (
  input  logic cfg_esf,
  input  logic cfg_b8zs_en,
  input  logic cfg_zero_mode,
  input  logic cfg_fs_count,
  input  logic los,
  input  logic ev_bpv,
  input  logic ev_bpv_code,
  input  logic ev_zero8,
  input  logic ev_zero16,
  input  logic ev_crc,
  input  logic ev_oof,
  input  logic ev_ft_err,
  input  logic ev_fs_err,
  input  logic ev_fps_err,
  output logic [err_cnt_pkg::N_CNT-1:0] inc
);
  import err_cnt_pkg::*;

  logic bpv_q, zero_q, fe_raw;

  always_comb begin
    bpv_q  = ev_bpv & ~(cfg_b8zs_en & ev_bpv_code);
    zero_q = cfg_b8zs_en ? ev_zero8 : ev_zero16;
    fe_raw = cfg_esf ? ev_fps_err : (ev_ft_err | (cfg_fs_count & ev_fs_err));
    inc[BV_IDX]  = cfg_zero_mode ? zero_q : bpv_q;
    inc[CRC_IDX] = cfg_esf & ~los & ev_crc;
    inc[OOF_IDX] = ~los & ev_oof;
    inc[FE_IDX]  = ~los & fe_raw;
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_zero,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  function automatic logic [W-1:0] sat_add(input logic [W-1:0] v, input logic up);
    return (up && v != MAXV) ? v + W'(1) : v;
  endfunction

  logic [W-1:0] base;

  always_comb begin
    if (load)     base = load_val;
    else if (clr) base = '0;
    else          base = count;
    ovf = ~hold_zero & inc & (base == MAXV);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold_zero) count <= '0;
    else                     count <= sat_add(base, inc);
  end
endmodule

// File: rtl/line_err_counters.sv
module line_err_counters (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_esf,
  input  logic       cfg_b8zs_en,
  input  logic       cfg_zero_mode,
  input  logic       cfg_fs_count,
  input  logic       cfg_auto_clr,
  input  logic       los,
  input  logic       ev_bpv,
  input  logic       ev_bpv_code,
  input  logic       ev_zero8,
  input  logic       ev_zero16,
  input  logic       ev_crc,
  input  logic       ev_oof,
  input  logic       ev_ft_err,
  input  logic       ev_fs_err,
  input  logic       ev_fps_err,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [3:0] irq_mask,
  output logic [3:0] sat_flag,
  output logic       irq
);
  import err_cnt_pkg::*;

  localparam int BV_W = 2 * REG_W;

  logic [N_CNT-1:0] inc;
  logic [N_CNT-1:0] ovf;
  logic [N_CNT-1:0] load;
  logic             rd_clear;
  logic [REG_W-1:0] lo_stage;
  logic [BV_W-1:0]  bv_cnt;
  logic [REG_W-1:0] small_cnt [1:N_CNT-1];

  assign rd_clear = reg_rd & cfg_auto_clr;

  ev_qualify u_qual (
    .cfg_esf(cfg_esf), .cfg_b8zs_en(cfg_b8zs_en), .cfg_zero_mode(cfg_zero_mode),
    .cfg_fs_count(cfg_fs_count), .los(los), .ev_bpv(ev_bpv), .ev_bpv_code(ev_bpv_code),
    .ev_zero8(ev_zero8), .ev_zero16(ev_zero16), .ev_crc(ev_crc), .ev_oof(ev_oof),
    .ev_ft_err(ev_ft_err), .ev_fs_err(ev_fs_err), .ev_fps_err(ev_fps_err), .inc(inc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) lo_stage <= '0;
    else if (reg_wr && reg_addr == A_BV_LO) lo_stage <= reg_wdata;
  end

  assign load[BV_IDX] = reg_wr && reg_addr == A_BV_HI;

  sat_counter #(.W(BV_W)) u_bv (
    .clk(clk), .rst_n(rst_n), .hold_zero(1'b0), .load(load[BV_IDX]),
    .load_val({reg_wdata, lo_stage}), .clr(rd_clear), .inc(inc[BV_IDX]),
    .count(bv_cnt), .ovf(ovf[BV_IDX])
  );

  for (genvar i = 1; i < N_CNT; i++) begin : g_small
    assign load[i] = reg_wr && reg_addr == small_addr(i);
    sat_counter #(.W(REG_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .hold_zero(i == CRC_IDX ? ~cfg_esf : 1'b0),
      .load(load[i]), .load_val(reg_wdata), .clr(rd_clear), .inc(inc[i]),
      .count(small_cnt[i]), .ovf(ovf[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sat_flag <= '0;
    else        sat_flag <= ovf | (sat_flag & ~load);
  end

  assign irq = |(sat_flag & irq_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        A_BV_LO: reg_rdata <= bv_cnt[REG_W-1:0];
        A_BV_HI: reg_rdata <= bv_cnt[BV_W-1:REG_W];
        A_CRC:   reg_rdata <= small_cnt[CRC_IDX];
        A_OOF:   reg_rdata <= small_cnt[OOF_IDX];
        A_FE:    reg_rdata <= small_cnt[FE_IDX];
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

module line_err_counters_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_esf,
  input logic        los,
  input logic        rd_clear,
  input logic [3:0]  inc,
  input logic [3:0]  ovf,
  input logic [3:0]  load,
  input logic [15:0] bv_cnt,
  input logic [7:0]  crc_cnt,
  input logic [7:0]  oof_cnt,
  input logic [3:0]  sat_flag,
  input logic [3:0]  irq_mask,
  input logic        irq
);
  // R3
  bv_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bv_cnt == 16'hFFFF && !load[0] && !rd_clear) |=> bv_cnt == 16'hFFFF);
  // R3
  oof_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oof_cnt == 8'hFF && !load[2] && !rd_clear) |=> oof_cnt == 8'hFF);
  // R4
  sat_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf[2] |=> sat_flag[2]);
  // R4
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sat_flag & irq_mask) != 4'b0);
  // R5
  los_oof_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (los && !load[2] && !rd_clear) |=> $stable(oof_cnt));
  // R6
  crc_sf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_esf |=> crc_cnt == 8'd0);
  // R10
  auto_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !load[2]) |=> oof_cnt == {7'd0, $past(inc[2])});
endmodule

bind line_err_counters line_err_counters_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_esf(cfg_esf), .los(los), .rd_clear(rd_clear),
  .inc(inc), .ovf(ovf), .load(load), .bv_cnt(bv_cnt),
  .crc_cnt(g_small[1].u_cnt.count), .oof_cnt(g_small[2].u_cnt.count),
  .sat_flag(sat_flag), .irq_mask(irq_mask), .irq(irq)
);

// File: tb/line_err_counters_tb_top.sv
module line_err_counters_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_esf = 0, cfg_b8zs_en = 0, cfg_zero_mode = 0, cfg_fs_count = 0, cfg_auto_clr = 0;
  logic los = 0;
  logic ev_bpv = 0, ev_bpv_code = 0, ev_zero8 = 0, ev_zero16 = 0, ev_crc = 0, ev_oof = 0;
  logic ev_ft_err = 0, ev_fs_err = 0, ev_fps_err = 0;
  logic [2:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [3:0] irq_mask = 0;
  logic [3:0] sat_flag;
  logic irq;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q [$];
  string tag_q [$];
  logic rd_seen = 0;

  always #5 clk = ~clk;

  line_err_counters dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against queued expectations
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("read_no_expect", 32'h1, 32'h0);
      else check(tag_q.pop_front(), {24'h0, reg_rdata}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic idle();
    @(negedge clk);
    reg_wr = 0; reg_rd = 0;
    ev_bpv = 0; ev_bpv_code = 0; ev_zero8 = 0; ev_zero16 = 0; ev_crc = 0;
    ev_oof = 0; ev_ft_err = 0; ev_fs_err = 0; ev_fps_err = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    idle();
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    idle();
  endtask

  task automatic pulses(int n, int which);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      case (which)
        0: ev_bpv = 1;
        1: ev_crc = 1;
        2: ev_oof = 1;
        3: ev_ft_err = 1;
        4: ev_fs_err = 1;
        5: ev_fps_err = 1;
        6: ev_zero8 = 1;
        7: ev_zero16 = 1;
        default: ;
      endcase
      idle();
    end
  endtask

  initial begin
    #2_000_000;
    check("watchdog", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 sat_flag", {28'h0, sat_flag}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd(0, 8'h00, "R1 bv_lo"); rd(1, 8'h00, "R1 bv_hi");
    rd(3, 8'h00, "R1 oof"); rd(4, 8'h00, "R1 fe"); rd(7, 8'h00, "R1 unused addr");

    // R3/R4 oof preset, saturate, overflow flag
    wr(3, 8'd253);
    pulses(2, 2);
    rd(3, 8'hFF, "R3 oof at max");
    check("R4 no flag at max", {28'h0, sat_flag}, 32'h0);
    pulses(1, 2);
    rd(3, 8'hFF, "R3 oof no wrap");
    check("R4 oof flag", {28'h0, sat_flag}, 32'h4);
    check("R4 irq masked", {31'h0, irq}, 32'h0);
    irq_mask = 4'h4; @(negedge clk);
    check("R4 irq enabled", {31'h0, irq}, 32'h1);
    wr(3, 8'd10);
    check("R2 write clears flag", {28'h0, sat_flag}, 32'h0);

    // R2 staged low byte
    wr(0, 8'hFE);
    rd(0, 8'h00, "R2 lo staged only");
    wr(1, 8'hFF);
    rd(0, 8'hFE, "R2 bv lo loaded"); rd(1, 8'hFF, "R2 bv hi loaded");
    pulses(1, 0);
    rd(0, 8'hFF, "R3 bv at max");
    pulses(1, 0);
    rd(1, 8'hFF, "R3 bv no wrap");
    check("R4 bv flag", {28'h0, sat_flag}, 32'h1);
    wr(0, 8'h00); wr(1, 8'h00);
    check("R2 bv flag cleared", {28'h0, sat_flag}, 32'h0);

    // R5 loss of sync
    los = 1;
    pulses(2, 2); pulses(2, 0); pulses(1, 3);
    rd(3, 8'd10, "R5 oof held in los");
    rd(4, 8'd0, "R5 fe held in los");
    rd(0, 8'd2, "R5 bv counts in los");
    los = 0;

    // R6 CRC hold in superframe
    wr(2, 8'd50);
    pulses(2, 1);
    rd(2, 8'd0, "R6 crc zero in sf");
    cfg_esf = 1;
    pulses(3, 1);
    rd(2, 8'd3, "R6 crc counts in esf");

    // R9 ESF frame errors: fps only
    pulses(2, 5); pulses(1, 3);
    rd(4, 8'd2, "R9 esf fps only");
    cfg_esf = 0;
    pulses(1, 3); pulses(1, 4);
    rd(4, 8'd3, "R9 sf ft only");
    cfg_fs_count = 1;
    pulses(1, 4); pulses(1, 5);
    rd(4, 8'd4, "R9 sf fs included");

    // R7 B8ZS code words
    cfg_b8zs_en = 1;
    @(negedge clk); ev_bpv = 1; ev_bpv_code = 1; idle();
    rd(0, 8'd2, "R7 code word excluded");
    cfg_b8zs_en = 0;
    @(negedge clk); ev_bpv = 1; ev_bpv_code = 1; idle();
    rd(0, 8'd3, "R7 code counted when b8zs off");

    // R8 excess zeros
    cfg_zero_mode = 1; cfg_b8zs_en = 1;
    pulses(2, 6); pulses(1, 7); pulses(1, 0);
    rd(0, 8'd5, "R8 zero8 with b8zs");
    cfg_b8zs_en = 0;
    pulses(1, 6); pulses(3, 7);
    rd(0, 8'd8, "R8 zero16 without b8zs");
    cfg_zero_mode = 0;

    // R10 auto clear
    rd(3, 8'd10, "R10 read no clear when off");
    rd(3, 8'd10, "R10 count kept");
    cfg_auto_clr = 1;
    @(negedge clk);
    reg_rd = 1; reg_addr = 3; ev_oof = 1;
    exp_q.push_back(8'd10); tag_q.push_back("R10 snapshot before clear");
    idle();
    rd(3, 8'd1, "R10 coincident event kept");
    cfg_auto_clr = 0;
    rd(0, 8'd0, "R10 bv cleared");
    rd(4, 8'd0, "R10 fe cleared");
    rd(3, 8'd0, "R10 oof cleared by prior read");

    repeat (3) @(negedge clk);
    check("queue drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule